// File: doc/BRIEF.md
# Multi-Channel Reloading Down-Counter Timer

This block is a memory-mapped timer with two or three independent 32-bit channels. Each channel counts down from a software-loaded value at a rate chosen by a per-channel prescaler. When the count passes below zero, the channel refills itself from its reload register and raises a sticky underflow flag. A single shared run register holds one bit per channel, so software can start or halt any channel without touching the others.

Software sets up a channel by writing its reload value, its starting count and its control word. The control word holds the prescaler code, the interrupt enable and the underflow flag. Software then sets the channel's run bit. Each channel drives its own interrupt line, which stays high while both the flag and the enable are set. The register port is a plain synchronous interface. A write is taken on the clock edge where `bus_wr` is high, and read data is a combinational function of `bus_addr`. A parameter selects between two register placements.

Top module: `ctmr_top`

## Requirements
- R1: In the default placement, the run register sits in bits 7:0 of byte offset 4. Channel n starts at byte offset 8+12n and holds its reload value at +0, its count at +4 and its control word at +8. With `ALT_MAP`=1, the run register sits in bits 23:16 of the word at offset 0, and channel n starts at 4+12n.
- R2: Run bit n (bit n of the run field) lets channel n count when it is 1. When it is 0, channel n's count holds its value. No run bit affects another channel.
- R3: Control bits 2:0 select the count rate. Codes 0, 1, 2, 3 and 4 give one tick per 4, 16, 64, 256 and 1024 clocks. Codes 5 to 7 behave like code 4.
- R4: After a run bit goes from 0 to 1, the first decrement happens one full prescale period later. For a division of D, that is D clock edges after the edge that captured the write.
- R5: The count drops by one on each tick. A tick that finds the count at zero loads the reload value instead and sets the underflow flag (control bit 8).
- R6: The reload and count registers are 32 bits wide and are written per byte lane under `bus_be`. Both reset to 0xFFFFFFFF. A write to the count overrides a tick in the same cycle.
- R7: The underflow flag is sticky. A write with lane 1 enabled and bit 8 at 0 clears it, and writing 1 has no effect. An underflow in the same cycle as a clearing write leaves the flag set.
- R8: A channel's `irq` bit is high exactly when its underflow flag and its interrupt enable (control bit 5) are both 1.
- R9: The control word resets to 0. Its bits other than 8, 5 and 2:0 read as zero. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 are ignored |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 4 | Byte lane enables for a write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | NUM_CH | Per-channel underflow interrupt |

## Verification
The counting path is driven with a short reload and count under the fastest divider. The bench samples edge by edge, which separates a correct start delay from an off-by-one prescaler and a reload from a wrap to 0xFFFFFFFF. A second channel runs at the /16 rate and a third at reserved code 7. These runs show that the decode of the code field is correct and that each run bit touches only its own channel. A clearing write is timed to land exactly on an underflow, which separates the set-wins ordering from a naive clear. Partial byte-enable writes, all-ones control writes and unmapped reads check the lane merge and the reserved-bit masking.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

    localparam int PSC_W  = 10;
    localparam int UF_BIT = 8;
    localparam int IE_BIT = 5;

    typedef struct packed {
        logic       uf;
        logic       ie;
        logic [2:0] psc;
    } ctl_t;

    // terminal value of the prescale counter for a given rate code
    function automatic logic [PSC_W-1:0] psc_limit(input logic [2:0] code);
        case (code)
            3'd0:    return PSC_W'(3);
            3'd1:    return PSC_W'(15);
            3'd2:    return PSC_W'(63);
            3'd3:    return PSC_W'(255);
            default: return PSC_W'(1023);
        endcase
    endfunction

    function automatic logic [31:0] ctl_word(input ctl_t c);
        logic [31:0] w;
        w         = '0;
        w[UF_BIT] = c.uf;
        w[IE_BIT] = c.ie;
        w[2:0]    = c.psc;
        return w;
    endfunction

    function automatic logic [31:0] be_merge(input logic [31:0] old_v,
                                             input logic [31:0] new_v,
                                             input logic [3:0]  be);
        logic [31:0] r;
        r = old_v;
        for (int b = 0; b < 4; b++)
            if (be[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
        return r;
    endfunction

endpackage

// File: rtl/ctmr_prescale.sv
module ctmr_prescale
    import ctmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [2:0] code,
    output logic       tick
);
    logic [PSC_W-1:0] pcnt;

    // held at zero while halted, so a restart waits a whole period
    assign tick = run && (pcnt >= psc_limit(code));

    always_ff @(posedge clk) begin
        if (rst || !run)
            pcnt <= '0;
        else if (tick)
            pcnt <= '0;
        else
            pcnt <= pcnt + 1'b1;
    end

    AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        tick |-> run); // R2
    AST_NO_TICK_AT_START: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> !tick); // R4
endmodule

// File: rtl/ctmr_channel.sv
module ctmr_channel
    import ctmr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        run,
    input  logic        wr_reload,
    input  logic        wr_count,
    input  logic        wr_ctl,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    output logic [31:0] reload_q,
    output logic [31:0] count_q,
    output ctl_t        ctl_q,
    output logic        irq
);
    logic tick;
    logic underflow;
    logic clr_req;

    ctmr_prescale u_psc (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .code (ctl_q.psc),
        .tick (tick)
    );

    assign underflow = tick && (count_q == '0);
    assign clr_req   = wr_ctl && be[1] && !wdata[UF_BIT];
    assign irq       = ctl_q.uf && ctl_q.ie;

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '1;
            count_q  <= '1;
            ctl_q    <= '0;
        end else begin
            if (wr_reload)
                reload_q <= be_merge(reload_q, wdata, be);
            if (wr_count)
                count_q <= be_merge(count_q, wdata, be);
            else if (tick)
                count_q <= underflow ? reload_q : count_q - 1'b1;
            if (wr_ctl && be[0]) begin
                ctl_q.psc <= wdata[2:0];
                ctl_q.ie  <= wdata[IE_BIT];
            end
            if (underflow)
                ctl_q.uf <= 1'b1;
            else if (clr_req)
                ctl_q.uf <= 1'b0;
        end
    end

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr_count) |=> $stable(count_q)); // R2
    AST_UNDERFLOW_RELOADS: assert property (@(posedge clk) disable iff (rst)
        (underflow && !wr_count) |=> (count_q == $past(reload_q))); // R5
    AST_UNDERFLOW_FLAGS: assert property (@(posedge clk) disable iff (rst)
        underflow |=> ctl_q.uf); // R7
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.uf && !clr_req) |=> ctl_q.uf); // R7
endmodule

// File: rtl/ctmr_top.sv
module ctmr_top
    import ctmr_pkg::*;
#(
    parameter int NUM_CH  = 3,
    parameter int ALT_MAP = 0,
    parameter int ADDR_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] irq
);
    localparam int WA_W     = ADDR_W - 2;
    localparam int RUN_BYTE = (ALT_MAP != 0) ? 2 : 4;
    localparam int RUN_WORD = RUN_BYTE / 4;
    localparam int RUN_LANE = RUN_BYTE % 4;
    localparam int CH0_WORD = ((ALT_MAP != 0) ? 4 : 8) / 4;

    generate
        if (NUM_CH < 2 || NUM_CH > 3) begin : g_bad_cfg
            $error("ctmr_top: NUM_CH must be 2 or 3");
        end
    endgenerate

    logic [WA_W-1:0]   word;
    logic              run_hit;
    logic [NUM_CH-1:0] run_q;
    logic              unused_lo;
    logic [31:0]       rl_q [NUM_CH];
    logic [31:0]       cn_q [NUM_CH];
    ctl_t              ct_q [NUM_CH];

    assign word      = bus_addr[ADDR_W-1:2];
    assign unused_lo = ^bus_addr[1:0];
    assign run_hit   = (word == WA_W'(RUN_WORD));

    always_ff @(posedge clk) begin
        if (rst)
            run_q <= '0;
        else if (bus_wr && run_hit && bus_be[RUN_LANE])
            run_q <= bus_wdata[RUN_LANE*8 +: NUM_CH];
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam int BASE = CH0_WORD + 3 * i;
        ctmr_channel u_ch (
            .clk       (clk),
            .rst       (rst),
            .run       (run_q[i]),
            .wr_reload (bus_wr && word == WA_W'(BASE)),
            .wr_count  (bus_wr && word == WA_W'(BASE + 1)),
            .wr_ctl    (bus_wr && word == WA_W'(BASE + 2)),
            .be        (bus_be),
            .wdata     (bus_wdata),
            .reload_q  (rl_q[i]),
            .count_q   (cn_q[i]),
            .ctl_q     (ct_q[i]),
            .irq       (irq[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (run_hit)
            bus_rdata[RUN_LANE*8 +: NUM_CH] = run_q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (word == WA_W'(CH0_WORD + 3 * i))     bus_rdata = rl_q[i];
            if (word == WA_W'(CH0_WORD + 3 * i + 1)) bus_rdata = cn_q[i];
            if (word == WA_W'(CH0_WORD + 3 * i + 2)) bus_rdata = ctl_word(ct_q[i]);
        end
    end

    AST_RUN_CLEAR_AFTER_RESET: assert property (@(posedge clk)
        rst |=> (run_q == '0)); // R2
endmodule

// File: tb/ctmr_top_tb_top.sv
`timescale 1ns/1ps
module ctmr_top_tb_top;
    localparam int NCH = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NCH-1:0] irq;

    always #2.5 clk = ~clk;

    ctmr_top #(.NUM_CH(NCH), .ALT_MAP(0), .ADDR_W(6)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    typedef struct {
        logic [31:0]    data;
        bit             chk_irq;
        logic [NCH-1:0] irq_v;
        string          tag;
    } item_t;

    item_t q[$];
    bit    probe = 1'b0;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    // monitor: pops one expected item per probed cycle
    always @(negedge clk) begin
        if (probe && q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            n_cmp++;
            if (bus_rdata !== it.data) begin
                n_bad++;
                $display("FAIL %s: rdata=%h expected %h", it.tag, bus_rdata, it.data);
            end
            if (it.chk_irq) begin
                n_cmp++;
                if (irq !== it.irq_v) begin
                    n_bad++;
                    $display("FAIL %s: irq=%b expected %b", it.tag, irq, it.irq_v);
                end
            end
        end
    end

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input int a, input logic [3:0] be, input logic [31:0] d);
        bus_addr = 6'(a); bus_be = be; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_be = '0;
    endtask

    // read reflects state after the most recent edge; consumes one edge
    task automatic rd(input int a, input logic [31:0] exp, input string tag,
                      input bit ci = 1'b0, input logic [NCH-1:0] ei = '0);
        item_t it;
        it.data = exp; it.chk_irq = ci; it.irq_v = ei; it.tag = tag;
        bus_addr = 6'(a);
        q.push_back(it);
        probe = 1'b1;
        @(negedge clk); #1;
        probe = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        finish_up();
    end

    initial begin
        edges(4);
        rst = 1'b0;
        #1;
        // reset state
        rd(4,  32'h0,        "R1 R2 run reg reset", 1'b1, 3'b000);
        rd(16, 32'h0,        "R9 ctl0 reset");
        rd(12, 32'hFFFF_FFFF, "R6 count0 reset");
        rd(20, 32'hFFFF_FFFF, "R6 reload1 reset");
        // unmapped + reserved bits
        rd(0,  32'h0, "R9 unmapped offset 0");
        rd(44, 32'h0, "R9 unmapped offset 44");
        wr(40, 4'hF, 32'hFFFF_FFFF);
        rd(40, 32'h0000_0027, "R9 R7 reserved bits and flag write-1", 1'b1, 3'b000);
        wr(40, 4'hF, 32'h0);

        // R4 R5: channel 0, /4, reload 2, count 5
        wr(8,  4'hF, 32'd2);
        wr(12, 4'hF, 32'd5);
        wr(16, 4'hF, 32'h20);
        wr(4,  4'h1, 32'h1);           // start captured at E0
        rd(12, 32'd5, "R4 count after start edge");
        edges(2);
        rd(12, 32'd5, "R4 count before first period ends");
        rd(12, 32'd4, "R4 R5 first decrement after 4 edges");
        edges(19);
        rd(16, 32'h0000_0120, "R5 R8 underflow flag and irq", 1'b1, 3'b001);
        rd(12, 32'd2, "R5 reload after underflow");
        // R2 halt
        wr(4, 4'h1, 32'h0);
        rd(12, 32'd2, "R2 count held after stop");
        edges(20);
        rd(12, 32'd2, "R2 count still held");
        // R7 flag write semantics
        wr(16, 4'h3, 32'h0120);
        rd(16, 32'h0000_0120, "R7 writing 1 keeps flag", 1'b1, 3'b001);
        wr(16, 4'h3, 32'h0020);
        rd(16, 32'h0000_0020, "R7 R8 writing 0 clears flag", 1'b1, 3'b000);
        // R7 clear coinciding with underflow
        wr(12, 4'hF, 32'd0);
        wr(8,  4'hF, 32'd0);
        wr(4,  4'h1, 32'h1);           // E0
        edges(3);
        wr(16, 4'h3, 32'h0020);        // lands on E4 underflow
        rd(16, 32'h0000_0120, "R7 underflow beats clear", 1'b1, 3'b001);
        wr(4, 4'h1, 32'h0);
        wr(16, 4'h3, 32'h0020);
        rd(16, 32'h0000_0020, "R7 cleared after stop");
        // R3 /16 on channel 1 only
        wr(24, 4'hF, 32'd100);
        wr(28, 4'hF, 32'h1);
        wr(4,  4'h1, 32'h2);           // E0
        rd(24, 32'd100, "R3 ch1 count after start");
        edges(14);
        rd(24, 32'd100, "R3 ch1 before 16 edges");
        rd(24, 32'd99,  "R3 R4 ch1 tick at 16 edges");
        rd(12, 32'd0,   "R2 ch0 unaffected by ch1 run");
        rd(4,  32'h2,   "R1 run reg readback");
        // R3 reserved code 7 acts as /1024 on channel 2
        wr(36, 4'hF, 32'd10);
        wr(40, 4'hF, 32'h7);
        wr(4,  4'h1, 32'h4);           // E0
        rd(36, 32'd10, "R3 ch2 after start");
        edges(1022);
        rd(36, 32'd10, "R3 ch2 before 1024 edges");
        rd(36, 32'd9,  "R3 ch2 tick at 1024 edges");
        wr(4, 4'h1, 32'h0);
        // R6 byte lanes and full width
        wr(36, 4'h1, 32'hFFFF_FFAB);
        rd(36, 32'h0000_00AB, "R6 lane 0 only write");
        wr(36, 4'hF, 32'h1234_5678);
        rd(36, 32'h1234_5678, "R6 full word write");
        wr(32, 4'hF, 32'hFFFF_FFFF);
        rd(32, 32'hFFFF_FFFF, "R6 longest reload");
        edges(2);
        finish_up();
    end
endmodule